// File: doc/BRIEF.md
# Incremental Block CRC Memory Verifier

This block confirms that a read-only memory region still holds its programmed contents. It works on one fixed-size block at a time. Each block's words are read in address order over a synchronous read port. Every word is folded into a CRC-32 register, and the result is compared with a golden value stored for that block. Because each check covers only one block, a single test step takes a short, known time. Software can place these steps between time-critical work and still reach full coverage over several steps.

There are two ways to start a check. A step strobe checks the next block named by a rotating index. A round strobe, or a periodic tick when periodic mode is enabled, walks every block from index 0 back to back. The round strobe is meant to be issued once after power-up, and the tick drives the repeated rounds that follow. For every block the block reports pass or fail. It keeps a sticky failure flag together with the index of the first failing block, and it pulses a flag when the last block of the region has been checked. The golden values sit in a small register array that is loaded through a write port.

Top module: `blk_crc_verifier`

## Requirements
- R1: The CRC for a block starts from 0xFFFFFFFF and uses polynomial 0x04C11DB7, taking each 32-bit word bit 31 first, with no reflection and no final XOR. The words are taken in increasing address order. `blockPass` is 1 exactly when that CRC equals the golden entry of the block, and it is valid in the cycle `blockDone` is high.
- R2: For each block, `memRdEn` is high for exactly BLOCK_WORDS consecutive cycles. `memAddr` runs from block*BLOCK_WORDS upward by one. Read data is taken one cycle after its read enable.
- R3: A `stepStart` sampled while idle checks block `curIdx`. `blockDone` is a one-cycle pulse that appears BLOCK_WORDS+2 clock edges after the start edge.
- R4: After each checked block, `curIdx` advances by one and wraps to 0 after the last block. `roundDone` pulses together with the `blockDone` of the last block.
- R5: A `roundStart` sampled while idle sets the index to 0 and checks all NUM_BLOCKS blocks back to back. `busy` stays high through the whole round, which ends with one `roundDone`.
- R6: `periodTick` starts a round like `roundStart` when `periodicEn` is 1, and it is ignored when `periodicEn` is 0.
- R7: `stepStart`, `roundStart` and `periodTick` are ignored while `busy` is 1.
- R8: A mismatch sets `failSticky` and records the block in `failIndex`, but only if no failure is already held. Later blocks are still checked. `failClear` clears `failSticky`, and a mismatch in the same cycle takes priority.
- R9: When `goldWe` is 1, `goldData` is written to golden entry `goldIdx`, and the new value takes effect for later checks.
- R10: While `rstN` is low, and right after reset, `busy`, `blockDone`, `roundDone`, `failSticky`, `memRdEn` and `curIdx` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| stepStart | input | 1 | Check the block at `curIdx` |
| roundStart | input | 1 | Check all blocks starting at index 0 |
| periodicEn | input | 1 | Lets `periodTick` start rounds |
| periodTick | input | 1 | Periodic round trigger |
| failClear | input | 1 | Clears `failSticky` |
| goldWe | input | 1 | Golden entry write enable |
| goldIdx | input | IDX_W | Golden entry index |
| goldData | input | 32 | Golden CRC value |
| memRdEn | output | 1 | Memory read enable |
| memAddr | output | ADDR_W | Memory word address |
| memRdData | input | 32 | Read data, one cycle after `memRdEn` |
| busy | output | 1 | A check is in progress |
| curIdx | output | IDX_W | Next block to check, or the block being checked |
| blockDone | output | 1 | One-cycle pulse when a block check completes |
| blockPass | output | 1 | Result of the last block check |
| roundDone | output | 1 | Pulse when the last block has been checked |
| failSticky | output | 1 | A mismatch has occurred since the last clear |
| failIndex | output | IDX_W | First failing block since the last clear |

## Verification
The assertions assume that the memory returns data exactly one cycle after a read enable, and that the golden array is not rewritten while a check is running. The bench keeps to both conditions. Its memory model is a one-cycle registered array, and it changes memory words and golden entries only while `busy` is low. The start strobes are held for a single cycle and driven between clock edges. The only strobes the bench raises during a check are the ones that the ignore requirement covers.

// File: rtl/blk_crc_pkg.sv
package blk_crc_pkg;

  localparam logic [31:0] CRC_POLY = 32'h04C11DB7;
  localparam logic [31:0] CRC_SEED = 32'hFFFFFFFF;

  // Strobes from the sequencer to the datapath
  typedef struct packed {
    logic crcClear;  // reload CRC seed
    logic rdIssue;   // issue one memory read
    logic compare;   // compare CRC with golden, update index and flags
    logic idxZero;   // restart index at block 0
  } ctlStrobe_t;

  // One 32-bit word folded into the CRC, MSB first
  function automatic logic [31:0] crcWord(input logic [31:0] crcIn, input logic [31:0] din);
    logic [31:0] c;
    logic fb;
    c = crcIn;
    for (int i = 31; i >= 0; i--) begin
      fb = c[31] ^ din[i];
      c  = {c[30:0], 1'b0};
      if (fb) c = c ^ CRC_POLY;
    end
    return c;
  endfunction

endpackage

// File: rtl/blk_crc_ctrl.sv
module blk_crc_ctrl
  import blk_crc_pkg::*;
#(
  parameter int BLOCK_WORDS = 8,
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             stepStart,
  input  logic             roundStart,
  input  logic             periodicEn,
  input  logic             periodTick,
  input  logic             isLastBlk,
  output ctlStrobe_t       ctl,
  output logic [CNT_W-1:0] wordCnt,
  output logic             busy
);

  localparam logic [CNT_W-1:0] LAST_WORD = CNT_W'(BLOCK_WORDS - 1);

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_DRAIN, S_CMP} state_t;

  state_t           st, stNext;
  logic [CNT_W-1:0] cntNext;
  logic             inRound, roundNext;
  logic             roundGo;

  assign roundGo = roundStart | (periodicEn & periodTick);
  assign busy    = (st != S_IDLE);

  always_comb begin
    ctl       = '0;
    stNext    = st;
    cntNext   = wordCnt;
    roundNext = inRound;
    unique case (st)
      S_IDLE: begin
        if (roundGo) begin
          ctl.idxZero  = 1'b1;
          ctl.crcClear = 1'b1;
          roundNext    = 1'b1;
          cntNext      = '0;
          stNext       = S_RUN;
        end else if (stepStart) begin
          ctl.crcClear = 1'b1;
          roundNext    = 1'b0;
          cntNext      = '0;
          stNext       = S_RUN;
        end
      end
      S_RUN: begin
        ctl.rdIssue = 1'b1;
        if (wordCnt == LAST_WORD) stNext = S_DRAIN;
        else cntNext = wordCnt + 1'b1;
      end
      S_DRAIN: stNext = S_CMP;
      S_CMP: begin
        ctl.compare = 1'b1;
        if (inRound && !isLastBlk) begin
          ctl.crcClear = 1'b1;
          cntNext      = '0;
          stNext       = S_RUN;
        end else begin
          stNext = S_IDLE;
        end
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      st      <= S_IDLE;
      wordCnt <= '0;
      inRound <= 1'b0;
    end else begin
      st      <= stNext;
      wordCnt <= cntNext;
      inRound <= roundNext;
    end
  end

endmodule

// File: rtl/blk_crc_datapath.sv
module blk_crc_datapath
  import blk_crc_pkg::*;
#(
  parameter int NUM_BLOCKS = 4,
  parameter int BLOCK_WORDS = 8,
  parameter int IDX_W = 2,
  parameter int ADDR_W = 5,
  parameter int CNT_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobe_t        ctl,
  input  logic [CNT_W-1:0]  wordCnt,
  input  logic              failClear,
  input  logic              goldWe,
  input  logic [IDX_W-1:0]  goldIdx,
  input  logic [31:0]       goldData,
  output logic              memRdEn,
  output logic [ADDR_W-1:0] memAddr,
  input  logic [31:0]       memRdData,
  output logic              isLastBlk,
  output logic [IDX_W-1:0]  curIdx,
  output logic              blockDone,
  output logic              blockPass,
  output logic              roundDone,
  output logic              failSticky,
  output logic [IDX_W-1:0]  failIndex
);

  logic [31:0] goldMem [NUM_BLOCKS];
  logic [31:0] crcReg;
  logic        rdValid;
  logic        match;

  // Golden value register array, one entry per block
  for (genvar g = 0; g < NUM_BLOCKS; g++) begin : g_gold
    always_ff @(posedge clk) begin
      if (!rstN) goldMem[g] <= '0;
      else if (goldWe && goldIdx == IDX_W'(g)) goldMem[g] <= goldData;
    end
  end

  assign isLastBlk = (curIdx == IDX_W'(NUM_BLOCKS - 1));
  assign memRdEn   = ctl.rdIssue;
  assign memAddr   = ADDR_W'(curIdx) * ADDR_W'(BLOCK_WORDS) + ADDR_W'(wordCnt);
  assign match     = (crcReg == goldMem[curIdx]);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdValid <= 1'b0;
      crcReg  <= CRC_SEED;
    end else begin
      rdValid <= ctl.rdIssue;
      if (ctl.crcClear) crcReg <= CRC_SEED;
      else if (rdValid) crcReg <= crcWord(crcReg, memRdData);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curIdx     <= '0;
      blockDone  <= 1'b0;
      blockPass  <= 1'b0;
      roundDone  <= 1'b0;
      failSticky <= 1'b0;
      failIndex  <= '0;
    end else begin
      blockDone <= ctl.compare;
      roundDone <= ctl.compare & isLastBlk;
      if (ctl.compare) blockPass <= match;
      if (ctl.idxZero) curIdx <= '0;
      else if (ctl.compare) curIdx <= isLastBlk ? '0 : curIdx + 1'b1;
      if (ctl.compare && !match) begin
        failSticky <= 1'b1;
        if (!failSticky || failClear) failIndex <= curIdx;
      end else if (failClear) begin
        failSticky <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/blk_crc_verifier.sv
module blk_crc_verifier
  import blk_crc_pkg::*;
#(
  parameter int NUM_BLOCKS = 4,
  parameter int BLOCK_WORDS = 8,
  localparam int IDX_W = (NUM_BLOCKS > 1) ? $clog2(NUM_BLOCKS) : 1,
  localparam int ADDR_W = (NUM_BLOCKS * BLOCK_WORDS > 1) ? $clog2(NUM_BLOCKS * BLOCK_WORDS) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              stepStart,
  input  logic              roundStart,
  input  logic              periodicEn,
  input  logic              periodTick,
  input  logic              failClear,
  input  logic              goldWe,
  input  logic [IDX_W-1:0]  goldIdx,
  input  logic [31:0]       goldData,
  output logic              memRdEn,
  output logic [ADDR_W-1:0] memAddr,
  input  logic [31:0]       memRdData,
  output logic              busy,
  output logic [IDX_W-1:0]  curIdx,
  output logic              blockDone,
  output logic              blockPass,
  output logic              roundDone,
  output logic              failSticky,
  output logic [IDX_W-1:0]  failIndex
);

  localparam int CNT_W = (BLOCK_WORDS > 1) ? $clog2(BLOCK_WORDS) : 1;

  ctlStrobe_t       ctl;
  logic [CNT_W-1:0] wordCnt;
  logic             isLastBlk;

  blk_crc_ctrl #(.BLOCK_WORDS(BLOCK_WORDS), .CNT_W(CNT_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .stepStart(stepStart), .roundStart(roundStart),
    .periodicEn(periodicEn), .periodTick(periodTick), .isLastBlk(isLastBlk),
    .ctl(ctl), .wordCnt(wordCnt), .busy(busy)
  );

  blk_crc_datapath #(
    .NUM_BLOCKS(NUM_BLOCKS), .BLOCK_WORDS(BLOCK_WORDS), .IDX_W(IDX_W),
    .ADDR_W(ADDR_W), .CNT_W(CNT_W)
  ) dp_i (
    .clk(clk), .rstN(rstN), .ctl(ctl), .wordCnt(wordCnt), .failClear(failClear),
    .goldWe(goldWe), .goldIdx(goldIdx), .goldData(goldData),
    .memRdEn(memRdEn), .memAddr(memAddr), .memRdData(memRdData),
    .isLastBlk(isLastBlk), .curIdx(curIdx), .blockDone(blockDone),
    .blockPass(blockPass), .roundDone(roundDone), .failSticky(failSticky),
    .failIndex(failIndex)
  );

endmodule

// File: rtl/blk_crc_verifier_chk.sv
module blk_crc_verifier_chk #(
  parameter int IDX_W = 2
) (
  input logic             clk,
  input logic             rstN,
  input logic             stepStart,
  input logic             roundStart,
  input logic             periodicEn,
  input logic             periodTick,
  input logic             failClear,
  input logic             memRdEn,
  input logic             busy,
  input logic [IDX_W-1:0] curIdx,
  input logic             blockDone,
  input logic             blockPass,
  input logic             roundDone,
  input logic             failSticky
);

  // R3
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    blockDone |=> !blockDone);

  // R2
  rd_in_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    memRdEn |-> busy);

  // R4
  round_with_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    roundDone |-> (blockDone && curIdx == '0));

  // R4
  idx_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (blockDone && !roundDone) |-> curIdx == IDX_W'($past(curIdx) + 1'b1));

  // R6
  tick_ignore_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !periodicEn && periodTick && !stepStart && !roundStart) |=> !busy);

  // R8
  sticky_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (failSticky && !failClear) |=> failSticky);

  // R8
  fail_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    (blockDone && !blockPass) |-> failSticky);

endmodule

bind blk_crc_verifier blk_crc_verifier_chk #(.IDX_W(IDX_W)) chk_i (
  .clk(clk), .rstN(rstN), .stepStart(stepStart), .roundStart(roundStart),
  .periodicEn(periodicEn), .periodTick(periodTick), .failClear(failClear),
  .memRdEn(memRdEn), .busy(busy), .curIdx(curIdx), .blockDone(blockDone),
  .blockPass(blockPass), .roundDone(roundDone), .failSticky(failSticky)
);

// File: tb/blk_crc_verifier_tb.sv
`timescale 1ns/1ps
module blk_crc_verifier_tb_top;

  localparam int NB = 4;
  localparam int BW = 8;
  localparam int IW = 2;
  localparam int AW = 5;
  localparam logic [31:0] POLY = 32'h04C11DB7;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic stepStart = 0, roundStart = 0, periodicEn = 0, periodTick = 0, failClear = 0;
  logic goldWe = 0;
  logic [IW-1:0] goldIdx = '0;
  logic [31:0] goldData = '0;
  logic memRdEn;
  logic [AW-1:0] memAddr;
  logic [31:0] memRdData;
  logic busy, blockDone, blockPass, roundDone, failSticky;
  logic [IW-1:0] curIdx, failIndex;

  int nChk = 0;
  int nFail = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  blk_crc_verifier #(.NUM_BLOCKS(NB), .BLOCK_WORDS(BW)) dut_i (
    .clk(clk), .rstN(rstN), .stepStart(stepStart), .roundStart(roundStart),
    .periodicEn(periodicEn), .periodTick(periodTick), .failClear(failClear),
    .goldWe(goldWe), .goldIdx(goldIdx), .goldData(goldData),
    .memRdEn(memRdEn), .memAddr(memAddr), .memRdData(memRdData),
    .busy(busy), .curIdx(curIdx), .blockDone(blockDone), .blockPass(blockPass),
    .roundDone(roundDone), .failSticky(failSticky), .failIndex(failIndex)
  );

  // memory model: one-cycle synchronous read
  logic [31:0] mem [NB*BW];
  always_ff @(posedge clk) if (memRdEn) memRdData <= mem[memAddr];

  typedef struct packed {
    logic [7:0]  flipAddr;
    logic [31:0] mask;
    logic        expPass;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{8'd0,  32'h0000_0000, 1'b1},
    '{8'd9,  32'h0000_0001, 1'b0},
    '{8'd20, 32'h8000_0000, 1'b0},
    '{8'd5,  32'h0000_00FF, 1'b1},
    '{8'd0,  32'h0000_0000, 1'b1},
    '{8'd15, 32'h0000_0003, 1'b0}
  };

  function automatic logic [31:0] refCrc(input int blk);
    logic [31:0] c = 32'hFFFFFFFF;
    for (int w = 0; w < BW; w++) begin
      c = c ^ mem[blk*BW + w];
      for (int b = 0; b < 32; b++) c = c[31] ? ((c << 1) ^ POLY) : (c << 1);
    end
    return c;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic writeGold(input int idx, input logic [31:0] val);
    @(negedge clk);
    goldWe = 1; goldIdx = IW'(idx); goldData = val;
    @(negedge clk);
    goldWe = 0;
  endtask

  // single step with latency and read-address tracking
  task automatic runStep(output int lat, output int nRd, output int badAddr, output int nRound);
    int base;
    base = int'(curIdx) * BW;
    lat = 0; nRd = 0; badAddr = 0; nRound = 0;
    @(negedge clk); stepStart = 1;
    tick(); stepStart = 0;
    while (!blockDone && lat < 100) begin
      if (memRdEn) begin
        if (int'(memAddr) != base + nRd) badAddr++;
        nRd++;
      end
      tick(); lat++;
    end
    if (roundDone) nRound++;
  endtask

  // count events over a window starting right after a start edge
  task automatic observe(input int cycles, output int nDone, output int nRound,
                         output int nBusy, output logic [7:0] passBits);
    nDone = 0; nRound = 0; nBusy = 0; passBits = '0;
    for (int c = 0; c < cycles; c++) begin
      if (busy) nBusy++;
      if (blockDone) begin
        passBits[nDone] = blockPass;
        nDone++;
      end
      if (roundDone) nRound++;
      tick();
    end
  endtask

  task automatic pulseRound();
    @(negedge clk); roundStart = 1;
    tick(); roundStart = 0;
  endtask

  task automatic pulseTick();
    @(negedge clk); periodTick = 1;
    tick(); periodTick = 0;
  endtask

  task automatic pulseClear();
    @(negedge clk); failClear = 1;
    @(negedge clk); failClear = 0;
  endtask

  initial begin
    int lat, nRd, badAddr, nRound, nDone, nBusy;
    logic [7:0] pb;
    for (int a = 0; a < NB*BW; a++) mem[a] = 32'h1357_9BDF * (a + 1) ^ (a << 24);

    repeat (4) tick();
    // R10: state during reset
    chk("R10 busy in reset", busy, 0);
    chk("R10 memRdEn in reset", memRdEn, 0);
    @(negedge clk); rstN = 1;
    tick();
    chk("R10 busy", busy, 0);
    chk("R10 blockDone", blockDone, 0);
    chk("R10 roundDone", roundDone, 0);
    chk("R10 failSticky", failSticky, 0);
    chk("R10 curIdx", curIdx, 0);

    // R9: load golden values
    for (int b = 0; b < NB; b++) writeGold(b, refCrc(b));

    // table-driven steps (R1 R2 R3 R4)
    for (int i = 0; i < 6; i++) begin
      mem[VECS[i].flipAddr] = mem[VECS[i].flipAddr] ^ VECS[i].mask;
      runStep(lat, nRd, badAddr, nRound);
      chk("R3 latency", lat, BW + 2);
      chk("R1 pass result", blockPass, VECS[i].expPass);
      chk("R2 read count", nRd, BW);
      chk("R2 address order", badAddr, 0);
      chk("R4 roundDone on last", nRound, (i % NB == NB - 1) ? 1 : 0);
      tick();
      chk("R4 index advance", curIdx, (i + 1) % NB);
      mem[VECS[i].flipAddr] = mem[VECS[i].flipAddr] ^ VECS[i].mask;
    end
    chk("R8 sticky set", failSticky, 1);
    chk("R8 first fail index", failIndex, 1);
    pulseClear();
    tick();
    chk("R8 clear", failSticky, 0);

    // R7: strobes while busy ignored (curIdx is 2)
    @(negedge clk); stepStart = 1;
    tick(); stepStart = 0;
    tick(); tick();
    @(negedge clk); stepStart = 1; roundStart = 1; periodicEn = 1; periodTick = 1;
    tick(); stepStart = 0; roundStart = 0; periodicEn = 0; periodTick = 0;
    observe(30, nDone, nRound, nBusy, pb);
    chk("R7 one block only", nDone, 1);
    chk("R7 index after ignored strobes", curIdx, 3);

    // R5: full round with corrupt blocks 1 and 3
    mem[12] = ~mem[12];
    mem[30] = mem[30] ^ 32'h0001_0000;
    pulseRound();
    observe(4*(BW+2) + 5, nDone, nRound, nBusy, pb);
    chk("R5 blocks in round", nDone, NB);
    chk("R5 roundDone count", nRound, 1);
    chk("R5 busy continuous", nBusy, NB*(BW+2));
    chk("R5 pass pattern", pb[3:0], 4'b0101);
    chk("R8 round first fail", failIndex, 1);
    chk("R5 index wraps", curIdx, 0);
    mem[12] = ~mem[12];
    mem[30] = mem[30] ^ 32'h0001_0000;
    pulseClear();

    // R6: tick ignored when disabled, starts round when enabled
    pulseTick();
    observe(15, nDone, nRound, nBusy, pb);
    chk("R6 tick disabled busy", nBusy, 0);
    chk("R6 tick disabled done", nDone, 0);
    @(negedge clk); periodicEn = 1;
    pulseTick();
    observe(4*(BW+2) + 5, nDone, nRound, nBusy, pb);
    chk("R6 periodic round blocks", nDone, NB);
    chk("R6 periodic round done", nRound, 1);
    chk("R6 all pass", pb[3:0], 4'b1111);
    chk("R8 no fail", failSticky, 0);
    @(negedge clk); periodicEn = 0;

    // R9: rewrite golden entry 0 with a wrong value
    writeGold(0, refCrc(0) ^ 32'h8000_0001);
    runStep(lat, nRd, badAddr, nRound);
    chk("R9 wrong golden fails", blockPass, 0);
    chk("R9 fail index", failIndex, 0);
    writeGold(0, refCrc(0));
    runStep(lat, nRd, badAddr, nRound);
    chk("R1 block1 pass", blockPass, 1);

    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", nChk, nFail);
      $finish;
    end
  end

  initial begin
    #(200000 * 4);
    if (!finished) begin
      finished = 1;
      nChk++; nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nChk, nFail);
      $finish;
    end
  end

endmodule